// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Register Bank

This block holds a hidden BCD clock (seconds, minutes, hours, day of week, date, month, two-digit year) that steps forward on each 1 Hz tick from an external prescaler. Software never sees those counters directly. It sees a visible copy of eight bytes placed at the very top of a byte address space. The bank copies the counters into that visible image once per second, always as a single step across all fields.

Two halt flags in the control byte govern the copy. One freezes the image so that software can read a coherent time while the counters keep running. The other also freezes the image, so that software can write new values into it. Clearing that flag moves all seven time bytes into the counters at once and asks the prescaler to restart its sub-second phase. A stop flag, kept in the top bit of the seconds byte, gates counting. A sign bit and a five-bit calibration magnitude sit in the control byte and are exported to the prescaler.

Top module: `rtc_regbank`

## Requirements
- R1: After reset, the bytes read as follows: year 00h, month 01h, date 01h, day 01h, hours 00h, minutes 00h, control 00h, and seconds 80h (STOP set). `osc_run` is 0.
- R2: The byte offsets within the top eight addresses are: 7 year, 6 month, 5 date, 4 day of week, 3 hours, 2 minutes, 1 seconds, 0 control. Read data appears on `bus_rdata` one cycle after `bus_rd`. A read of any other address returns 00h, and a write to any other address changes nothing.
- R3: Seconds bit 7 is STOP, and `osc_run` is its inverse. Ticks are ignored while STOP is 1. A write that changes STOP from 1 to 0 pulses `prescale_restart` for one cycle.
- R4: Each tick increments the seconds. Seconds and minutes wrap from 59 to 00, and hours wrap from 23 to 00. The day of week wraps from 07 to 01 whenever the hour wraps, independently of the date.
- R5: The date rolls over after the last day of the month: 31 days for months 01, 03, 05, 07, 08, 10 and 12; 30 days for months 04, 06, 09 and 11; and for month 02, 29 days when the BCD year is a multiple of 4 (including 00), otherwise 28.
- R6: Rolling over past 12-31 23:59:59 moves the month to 01 and the year up by one, with year 99 wrapping to 00.
- R7: Control bit 6 (read halt) set to 1 freezes the visible bytes while the counters keep running. After it clears, the next tick shows the current count.
- R8: Control bit 7 (write halt) set to 1 freezes the visible bytes and lets software write them. A write that clears it copies all seven time bytes into the counters and pulses `prescale_restart` for one cycle.
- R9: A refresh that begins on a tick finishes even if a halt flag is written in the very next cycle, so the visible bytes then hold the value from that tick.
- R10: Bits that must be zero always read 0: month bits 7:5, date bits 7:6, day bits 7:3, hours bits 7:6, minutes bit 7.
- R11: Control bit 5 drives `cal_sign` and bits 4:0 drive `cal_mag`. The control byte reads back exactly as it was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse per second from the prescaler |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid the cycle after the strobe |
| osc_run | output | 1 | High while counting is enabled (STOP clear) |
| prescale_restart | output | 1 | One-cycle request to restart the sub-second phase |
| cal_sign | output | 1 | Calibration direction |
| cal_mag | output | CAL_W | Calibration magnitude |

## Verification
The bench builds the bank with the default 17-bit address and 5-bit calibration field, so the register offsets sit at their full-width top-of-space positions and any decode that ignores upper address bits shows up on a low-address probe. The bench loads end-of-day times through the write halt, which puts every month length, both leap and non-leap February, the year wrap and the day-of-week wrap one tick away. It also places a halt write in the cycle right after a tick, which makes the in-flight refresh observable.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef struct packed {
        logic [7:0] yr;
        logic [7:0] mon;
        logic [7:0] date;
        logic [7:0] dow;
        logic [7:0] hr;
        logic [7:0] mn;
        logic [7:0] sec;
    } rtc_time_t;

    typedef enum logic [2:0] {
        OFS_CTRL = 3'd0,
        OFS_SEC  = 3'd1,
        OFS_MIN  = 3'd2,
        OFS_HOUR = 3'd3,
        OFS_DOW  = 3'd4,
        OFS_DATE = 3'd5,
        OFS_MON  = 3'd6,
        OFS_YEAR = 3'd7
    } rtc_ofs_e;

    localparam rtc_time_t TIME_RESET = '{
        yr: 8'h00, mon: 8'h01, date: 8'h01, dow: 8'h01,
        hr: 8'h00, mn: 8'h00, sec: 8'h00
    };

    // writable bits per byte; seconds bit 7 is held apart as STOP
    function automatic logic [7:0] field_mask(input rtc_ofs_e ofs);
        case (ofs)
            OFS_SEC:  return 8'h7F;
            OFS_MIN:  return 8'h7F;
            OFS_HOUR: return 8'h3F;
            OFS_DOW:  return 8'h07;
            OFS_DATE: return 8'h3F;
            OFS_MON:  return 8'h1F;
            default:  return 8'hFF;
        endcase
    endfunction

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic bcd_leap(input logic [7:0] yr);
        if (!yr[4])
            return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
        return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    endfunction

    function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
        case (mon)
            8'h02:                      return bcd_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_next_time.sv
module rtc_next_time
    import rtc_pkg::*;
(
    input  rtc_time_t cur,
    output rtc_time_t nxt
);
    logic c_sec, c_min, c_hr, c_day, c_mon;

    always_comb begin
        nxt   = cur;
        c_sec = (cur.sec == 8'h59);
        c_min = c_sec && (cur.mn == 8'h59);
        c_hr  = c_min && (cur.hr == 8'h23);
        c_day = c_hr && (cur.date == month_last(cur.mon, cur.yr));
        c_mon = c_day && (cur.mon == 8'h12);

        nxt.sec = c_sec ? 8'h00 : bcd_inc(cur.sec);
        if (c_sec)
            nxt.mn = c_min ? 8'h00 : bcd_inc(cur.mn);
        if (c_min)
            nxt.hr = c_hr ? 8'h00 : bcd_inc(cur.hr);
        if (c_hr) begin
            nxt.dow  = (cur.dow == 8'h07) ? 8'h01 : bcd_inc(cur.dow);
            nxt.date = c_day ? 8'h01 : bcd_inc(cur.date);
        end
        if (c_day)
            nxt.mon = c_mon ? 8'h01 : bcd_inc(cur.mon);
        if (c_mon)
            nxt.yr = (cur.yr == 8'h99) ? 8'h00 : bcd_inc(cur.yr);
    end
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      advance,
    input  logic      load,
    input  rtc_time_t load_val,
    output rtc_time_t cnt
);
    rtc_time_t stepped;

    rtc_next_time u_next (
        .cur (cnt),
        .nxt (stepped)
    );

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= TIME_RESET;
        else if (load)
            cnt <= load_val;
        else if (advance)
            cnt <= stepped;
    end
endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int CAL_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              advanced,
    input  rtc_time_t         cnt,
    output rtc_time_t         vis,
    output logic [7:0]        bus_rdata,
    output logic              stop,
    output logic              rd_halt,
    output logic              wr_halt,
    output logic              refresh_pend,
    output logic              load_req,
    output logic              restart,
    output logic              cal_sign,
    output logic [CAL_W-1:0]  cal_mag
);
    localparam int HI_W = ADDR_W - 3;

    logic       hit;
    rtc_ofs_e   ofs;
    logic       wr_hit;
    logic       stop_clear;
    logic [7:0] ctrl_byte;
    logic [7:0] rd_mux;
    logic [7:0] wmask;

    assign hit        = &bus_addr[ADDR_W-1:3];
    assign ofs        = rtc_ofs_e'(bus_addr[2:0]);
    assign wr_hit     = bus_wr && hit;
    assign wmask      = field_mask(ofs);
    assign load_req   = wr_hit && (ofs == OFS_CTRL) && wr_halt && !bus_wdata[7];
    assign stop_clear = wr_hit && (ofs == OFS_SEC) && stop && !bus_wdata[7];

    generate
        if (CAL_W >= 5) begin : g_ctrl_full
            assign ctrl_byte = {wr_halt, rd_halt, cal_sign, cal_mag[4:0]};
        end else begin : g_ctrl_pad
            assign ctrl_byte = {wr_halt, rd_halt, cal_sign, {(5-CAL_W){1'b0}}, cal_mag};
        end
    endgenerate

    always_comb begin
        case (ofs)
            OFS_CTRL: rd_mux = ctrl_byte;
            OFS_SEC:  rd_mux = {stop, vis.sec[6:0]};
            OFS_MIN:  rd_mux = vis.mn;
            OFS_HOUR: rd_mux = vis.hr;
            OFS_DOW:  rd_mux = vis.dow;
            OFS_DATE: rd_mux = vis.date;
            OFS_MON:  rd_mux = vis.mon;
            default:  rd_mux = vis.yr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vis          <= TIME_RESET;
            stop         <= 1'b1;
            rd_halt      <= 1'b0;
            wr_halt      <= 1'b0;
            cal_sign     <= 1'b0;
            cal_mag      <= '0;
            refresh_pend <= 1'b0;
            restart      <= 1'b0;
            bus_rdata    <= 8'h00;
        end else begin
            restart      <= load_req || stop_clear;
            refresh_pend <= advanced && !rd_halt && !wr_halt;
            if (refresh_pend)
                vis <= cnt;
            if (wr_hit) begin
                case (ofs)
                    OFS_CTRL: begin
                        wr_halt  <= bus_wdata[7];
                        rd_halt  <= bus_wdata[6];
                        cal_sign <= bus_wdata[5];
                        cal_mag  <= bus_wdata[CAL_W-1:0];
                    end
                    OFS_SEC: begin
                        stop    <= bus_wdata[7];
                        vis.sec <= bus_wdata & wmask;
                    end
                    OFS_MIN:  vis.mn   <= bus_wdata & wmask;
                    OFS_HOUR: vis.hr   <= bus_wdata & wmask;
                    OFS_DOW:  vis.dow  <= bus_wdata & wmask;
                    OFS_DATE: vis.date <= bus_wdata & wmask;
                    OFS_MON:  vis.mon  <= bus_wdata & wmask;
                    default:  vis.yr   <= bus_wdata & wmask;
                endcase
            end
            if (bus_rd)
                bus_rdata <= hit ? rd_mux : 8'h00;
        end
    end

    logic unused_hi;
    assign unused_hi = ^{HI_W{1'b0}};
endmodule

// File: rtl/rtc_regbank.sv
module rtc_regbank
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int CAL_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    output logic              osc_run,
    output logic              prescale_restart,
    output logic              cal_sign,
    output logic [CAL_W-1:0]  cal_mag
);
    rtc_time_t cnt;
    rtc_time_t vis;
    logic      stop, rd_halt, wr_halt, refresh_pend, load_req, advanced;

    assign advanced = tick_1hz && !stop && !load_req;
    assign osc_run  = !stop;

    rtc_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .advance  (advanced),
        .load     (load_req),
        .load_val (vis),
        .cnt      (cnt)
    );

    rtc_shadow #(.ADDR_W(ADDR_W), .CAL_W(CAL_W)) u_shadow (
        .clk          (clk),
        .rst          (rst),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .advanced     (advanced),
        .cnt          (cnt),
        .vis          (vis),
        .bus_rdata    (bus_rdata),
        .stop         (stop),
        .rd_halt      (rd_halt),
        .wr_halt      (wr_halt),
        .refresh_pend (refresh_pend),
        .load_req     (load_req),
        .restart      (prescale_restart),
        .cal_sign     (cal_sign),
        .cal_mag      (cal_mag)
    );
endmodule

// File: rtl/rtc_regbank_chk.sv
module rtc_regbank_chk
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int CAL_W  = 5
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [7:0]        bus_rdata,
    input logic              osc_run,
    input logic [CAL_W-1:0]  cal_mag,
    input logic              stop,
    input logic              rd_halt,
    input logic              refresh_pend,
    input logic              load_req,
    input rtc_time_t         cnt,
    input rtc_time_t         vis
);
    localparam logic [ADDR_W-1:0] A_TOP  = '1;
    localparam logic [ADDR_W-1:0] A_MON  = A_TOP - 1;
    localparam logic [ADDR_W-1:0] A_SEC  = A_TOP - 6;
    localparam logic [ADDR_W-1:0] A_CTRL = A_TOP - 7;

    // R3
    stop_run_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_SEC) |=> (osc_run == !$past(bus_wdata[7])));

    // R3
    stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (stop && !load_req) |=> $stable(cnt));

    // R7
    freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_halt && !refresh_pend && !bus_wr) |=> $stable(vis));

    // R8
    load_copy_chk: assert property (@(posedge clk) disable iff (rst)
        load_req |=> (cnt == $past(vis)));

    // R10
    mon_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == A_MON) |=> (bus_rdata[7:5] == 3'b000));

    // R11
    cal_out_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_CTRL) |=> (cal_mag == $past(bus_wdata[CAL_W-1:0])));
endmodule

bind rtc_regbank rtc_regbank_chk #(.ADDR_W(ADDR_W), .CAL_W(CAL_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_rdata    (bus_rdata),
    .osc_run      (osc_run),
    .cal_mag      (cal_mag),
    .stop         (stop),
    .rd_halt      (rd_halt),
    .refresh_pend (refresh_pend),
    .load_req     (load_req),
    .cnt          (cnt),
    .vis          (vis)
);

// File: tb/rtc_regbank_test.sv
module rtc_regbank_test;
    localparam logic [16:0] A_YR   = 17'h1FFFF;
    localparam logic [16:0] A_MON  = 17'h1FFFE;
    localparam logic [16:0] A_DATE = 17'h1FFFD;
    localparam logic [16:0] A_DOW  = 17'h1FFFC;
    localparam logic [16:0] A_HR   = 17'h1FFFB;
    localparam logic [16:0] A_MIN  = 17'h1FFFA;
    localparam logic [16:0] A_SEC  = 17'h1FFF9;
    localparam logic [16:0] A_CTRL = 17'h1FFF8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_1hz = 1'b0;
    logic [16:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic        osc_run, prescale_restart, cal_sign;
    logic [4:0]  cal_mag;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } exp_t;
    exp_t exp_q[$];
    logic rd_seen = 1'b0;

    always #10 clk = ~clk;

    rtc_regbank uut (
        .clk              (clk),
        .rst              (rst),
        .tick_1hz         (tick_1hz),
        .bus_addr         (bus_addr),
        .bus_wdata        (bus_wdata),
        .bus_wr           (bus_wr),
        .bus_rd           (bus_rd),
        .bus_rdata        (bus_rdata),
        .osc_run          (osc_run),
        .prescale_restart (prescale_restart),
        .cal_sign         (cal_sign),
        .cal_mag          (cal_mag)
    );

    always @(posedge clk) rd_seen <= bus_rd;

    // monitor: pops one expectation per completed read
    always @(negedge clk) begin
        if (rd_seen) begin
            exp_t e;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected read data %02h", bus_rdata);
            end else begin
                e = exp_q.pop_front();
                if (bus_rdata !== e.exp) begin
                    errors++;
                    $display("FAIL %s: actual %02h expected %02h", e.tag, bus_rdata, e.exp);
                end
            end
        end
    end

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [16:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [16:0] a, input logic [7:0] exp, input string tag);
        exp_t e;
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        e.exp = exp; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_1hz = 1'b1;
            @(negedge clk); tick_1hz = 1'b0;
        end
    endtask

    task automatic set_time(input logic [7:0] yr, mon, date, dow, hr, mn, sec);
        bus_write(A_CTRL, 8'h80);
        bus_write(A_YR, yr);   bus_write(A_MON, mon); bus_write(A_DATE, date);
        bus_write(A_DOW, dow); bus_write(A_HR, hr);   bus_write(A_MIN, mn);
        bus_write(A_SEC, sec);
        bus_write(A_CTRL, 8'h00);
        check({7'd0, prescale_restart}, 8'h01, "R8 restart on load");
    endtask

    task automatic expect_time(input logic [7:0] yr, mon, date, dow, hr, mn, sec,
                               input string tag);
        bus_read(A_YR, yr, tag);   bus_read(A_MON, mon, tag); bus_read(A_DATE, date, tag);
        bus_read(A_DOW, dow, tag); bus_read(A_HR, hr, tag);   bus_read(A_MIN, mn, tag);
        bus_read(A_SEC, sec, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check({7'd0, osc_run}, 8'h00, "R1 osc_run");
        expect_time(8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h80, "R1 reset");
        bus_read(A_CTRL, 8'h00, "R1 ctrl");

        // R3 ticks ignored under STOP, restart on clear
        tick(2);
        bus_read(A_SEC, 8'h80, "R3 stopped");
        bus_write(A_SEC, 8'h00);
        check({7'd0, prescale_restart}, 8'h01, "R3 restart on stop clear");
        check({7'd0, osc_run}, 8'h01, "R3 osc_run");
        @(negedge clk);
        check({7'd0, prescale_restart}, 8'h00, "R3 restart one cycle");
        tick(3);
        bus_read(A_SEC, 8'h03, "R3 counting");
        bus_write(A_SEC, 8'h80);
        check({7'd0, osc_run}, 8'h00, "R3 osc stopped");
        tick(2);
        bus_read(A_SEC, 8'h80, "R3 no refresh while stopped");
        bus_write(A_SEC, 8'h00);
        tick(1);
        bus_read(A_SEC, 8'h04, "R3 counter held at 3");

        // R4 R5 rollovers
        set_time(8'h24, 8'h02, 8'h28, 8'h07, 8'h23, 8'h59, 8'h59);
        tick(1);
        expect_time(8'h24, 8'h02, 8'h29, 8'h01, 8'h00, 8'h00, 8'h00, "R5 leap feb28 / R4 dow wrap");
        set_time(8'h24, 8'h02, 8'h29, 8'h03, 8'h23, 8'h59, 8'h59);
        tick(1);
        expect_time(8'h24, 8'h03, 8'h01, 8'h04, 8'h00, 8'h00, 8'h00, "R5 leap feb29");
        set_time(8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59);
        tick(1);
        expect_time(8'h23, 8'h03, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00, "R5 common feb28");
        set_time(8'h00, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59);
        tick(1);
        expect_time(8'h00, 8'h02, 8'h29, 8'h03, 8'h00, 8'h00, 8'h00, "R5 year 00 leap");
        set_time(8'h24, 8'h04, 8'h30, 8'h05, 8'h23, 8'h59, 8'h59);
        tick(1);
        expect_time(8'h24, 8'h05, 8'h01, 8'h06, 8'h00, 8'h00, 8'h00, "R5 30-day month");
        set_time(8'h24, 8'h01, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59);
        tick(1);
        expect_time(8'h24, 8'h01, 8'h31, 8'h02, 8'h00, 8'h00, 8'h00, "R5 31-day month");
        set_time(8'h24, 8'h03, 8'h10, 8'h02, 8'h10, 8'h59, 8'h59);
        tick(1);
        expect_time(8'h24, 8'h03, 8'h10, 8'h02, 8'h11, 8'h00, 8'h00, "R4 hour carry");
        // R6
        set_time(8'h99, 8'h12, 8'h31, 8'h06, 8'h23, 8'h59, 8'h59);
        tick(1);
        expect_time(8'h00, 8'h01, 8'h01, 8'h07, 8'h00, 8'h00, 8'h00, "R6 year wrap");

        // R7 read halt
        set_time(8'h24, 8'h06, 8'h15, 8'h03, 8'h10, 8'h00, 8'h00);
        bus_write(A_CTRL, 8'h40);
        tick(2);
        bus_read(A_SEC, 8'h00, "R7 frozen");
        bus_write(A_CTRL, 8'h00);
        check({7'd0, prescale_restart}, 8'h00, "R7 no restart");
        tick(1);
        bus_read(A_SEC, 8'h03, "R7 counters ran");

        // R8 write halt
        bus_write(A_CTRL, 8'h80);
        tick(1);
        bus_read(A_SEC, 8'h03, "R8 frozen");
        bus_write(A_MIN, 8'h30);
        bus_write(A_SEC, 8'h10);
        bus_write(A_CTRL, 8'h00);
        check({7'd0, prescale_restart}, 8'h01, "R8 restart");
        tick(1);
        bus_read(A_MIN, 8'h30, "R8 loaded min");
        bus_read(A_SEC, 8'h11, "R8 loaded sec");

        // R9 halt in the cycle after a tick
        @(negedge clk); tick_1hz = 1'b1;
        @(negedge clk); tick_1hz = 1'b0;
        bus_addr = A_CTRL; bus_wdata = 8'h40; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        bus_read(A_SEC, 8'h12, "R9 refresh completed");
        tick(1);
        bus_read(A_SEC, 8'h12, "R9 then frozen");
        bus_write(A_CTRL, 8'h00);
        tick(1);
        bus_read(A_SEC, 8'h14, "R9 resumed");

        // R10 zero bits
        bus_write(A_CTRL, 8'h40);
        bus_write(A_MON, 8'hFF);  bus_read(A_MON, 8'h1F, "R10 month");
        bus_write(A_DATE, 8'hFF); bus_read(A_DATE, 8'h3F, "R10 date");
        bus_write(A_DOW, 8'hFF);  bus_read(A_DOW, 8'h07, "R10 day");
        bus_write(A_HR, 8'hFF);   bus_read(A_HR, 8'h3F, "R10 hours");
        bus_write(A_MIN, 8'hFF);  bus_read(A_MIN, 8'h7F, "R10 minutes");
        bus_write(A_CTRL, 8'h00);
        tick(1);
        bus_read(A_MON, 8'h06, "R7 refresh restores month");

        // R11 calibration
        bus_write(A_CTRL, 8'h35);
        check({7'd0, cal_sign}, 8'h01, "R11 cal_sign");
        check({3'd0, cal_mag}, 8'h15, "R11 cal_mag");
        bus_read(A_CTRL, 8'h35, "R11 ctrl readback");

        // R2 decode
        bus_write(17'h00010, 8'hAA);
        bus_read(17'h00010, 8'h00, "R2 outside read");
        bus_write(17'h00008, 8'hC0);
        bus_read(A_CTRL, 8'h35, "R2 outside write ignored");
        bus_read(17'h1FFF7, 8'h00, "R2 below bank");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R2 reads left unanswered: %0d", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule